// File: doc/BRIEF.md
# Serial Control Word Port with Early Temperature Flag

This block is the serial slave front end of a multi-channel half-bridge controller. A host writes 16-bit command words that set the high-side and low-side enables, pick which channels follow the shared PWM input, arm overcurrent shutdown and release the inhibit state. In the same frame the block returns a 16-bit status word built from status inputs supplied by the fault logic.

The temperature warning flag is the most significant bit of the reply. It is driven onto the data output as soon as chip select goes low, before any serial clock edge. A host can therefore poll temperature by lowering chip select, reading one bit and raising chip select again. A frame that ends with any bit count other than 16 is dropped completely. The serial clock, chip select and data input are oversampled by the system clock through synchronisers. The command fields leave the block as registered outputs.

Top module: `spi_ctl_top`

## Requirements
- R1: After reset all command outputs are 0 (drivers inhibited, run_en low), fault_reset is low and spi_sdo_oe is low.
- R2: Within a few system clocks of spi_cs_n falling, and before any spi_sclk edge, spi_sdo carries temp_warn as sampled at that falling edge.
- R3: A frame in which spi_cs_n rises after any count of spi_sclk rising edges other than 16 (0 to 15, or 17 and more) changes no command output and produces no fault_reset pulse.
- R4: When a frame of exactly 16 spi_sclk rising edges ends, the received word w, MSB first, loads hs_on=w[15:13], ls_on=w[12:10], pwm_hs_sel=w[9:7], pwm_ls_sel=w[6:4], oc_shutdown_en=w[3] and run_en=w[1]. Bit 0 is ignored, and within each 3-bit field the channel 3 value is the MSB.
- R5: The reply word, shifted MSB first, is {temp_warn, hs_stat[2:0], ls_stat[2:0], 8'b0, overload}. It is captured once when spi_cs_n falls, so status changes during the frame do not alter it.
- R6: Mode 0 timing: spi_sdi is sampled on spi_sclk rising edges and spi_sdo advances on falling edges.
- R7: A complete frame with w[2]=1 gives exactly one fault_reset pulse, one clock wide. w[2] is not stored, and w[2]=0 gives no pulse.
- R8: spi_sdo_oe is high while a frame is in progress and low while spi_cs_n is high.
- R9: Frames are received and decoded normally while run_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host (idles low) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_sdi | input | 1 | Serial data from host |
| spi_sdo | output | 1 | Serial data to host |
| spi_sdo_oe | output | 1 | Output enable for spi_sdo (high during a frame) |
| temp_warn | input | 1 | Temperature warning status |
| hs_stat | input | 3 | High-side per-channel status |
| ls_stat | input | 3 | Low-side per-channel status |
| overload | input | 1 | Overload status |
| hs_on | output | 3 | High-side enables |
| ls_on | output | 3 | Low-side enables |
| pwm_hs_sel | output | 3 | High-side channels gated by PWM |
| pwm_ls_sel | output | 3 | Low-side channels gated by PWM |
| oc_shutdown_en | output | 1 | Overcurrent shutdown armed |
| run_en | output | 1 | Drivers released from inhibit |
| fault_reset | output | 1 | One-cycle fault reset request |

## Verification
A wrong bit counter or a bad commit condition shows up as changed command outputs after a short or long frame, or as outputs that stay unchanged after a good frame. Either one is visible a few clocks after chip select rises. A wrong snapshot or wrong shift timing corrupts the reply word, and a swap of the TP bit appears at once on spi_sdo before the first serial clock. The bench sweeps every combination of the eight status inputs with varied command words, and it runs every partial bit count from 0 to 17.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
    localparam int WORD_W  = 16;
    localparam int CH      = 3;
    // command word positions
    localparam int HS_MSB  = 15;
    localparam int LS_MSB  = 12;
    localparam int PH_MSB  = 9;
    localparam int PL_MSB  = 6;
    localparam int OCS_BIT = 3;
    localparam int SRR_BIT = 2;
    localparam int SI_BIT  = 1;
    // reply word positions
    localparam int TP_BIT  = 15;
    localparam int HSS_MSB = 14;
    localparam int LSS_MSB = 11;
    localparam int OVL_BIT = 0;

    typedef struct packed {
        logic [CH-1:0] hs;
        logic [CH-1:0] ls;
        logic [CH-1:0] ph;
        logic [CH-1:0] pl;
        logic          ocs;
        logic          si;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.hs  = w[HS_MSB -: CH];
        c.ls  = w[LS_MSB -: CH];
        c.ph  = w[PH_MSB -: CH];
        c.pl  = w[PL_MSB -: CH];
        c.ocs = w[OCS_BIT];
        c.si  = w[SI_BIT];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] build_status(
        input logic tp, input logic [CH-1:0] hs, input logic [CH-1:0] ls,
        input logic ovl);
        logic [WORD_W-1:0] w;
        w = '0;
        w[TP_BIT]        = tp;
        w[HSS_MSB -: CH] = hs;
        w[LSS_MSB -: CH] = ls;
        w[OVL_BIT]       = ovl;
        return w;
    endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int          STAGES = 2,
    parameter int          N      = 3,
    parameter logic [2:0]  INIT   = 3'b000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][N-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int k = 1; k < DEPTH; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) pipe_q[k] <= INIT[N-1:0];
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign lvl  = pipe_q[STAGES-1];
    assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
    import spi_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi,
    input  logic [WORD_W-1:0] stat_word,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              commit,
    output logic [WORD_W-1:0] rx_word
);
    localparam int CW = $clog2(WORD_W + 2);
    localparam logic [CW-1:0] CNT_FULL = CW'(WORD_W);
    localparam logic [CW-1:0] CNT_SAT  = CW'(WORD_W + 1);

    typedef struct packed {
        logic              active;
        logic [CW-1:0]     cnt;
        logic [WORD_W-1:0] rx;
        logic [WORD_W-1:0] tx;
        logic              commit;
        logic [WORD_W-1:0] word;
    } sh_t;

    sh_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.commit = 1'b0;
        if (cs_fall) begin
            s_d.active = 1'b1;
            s_d.cnt    = '0;
            s_d.tx     = stat_word;
        end else if (cs_rise) begin
            s_d.active = 1'b0;
            if (s_q.active && s_q.cnt == CNT_FULL) begin
                s_d.commit = 1'b1;
                s_d.word   = s_q.rx;
            end
        end else if (s_q.active) begin
            if (sck_rise) begin
                s_d.rx = {s_q.rx[WORD_W-2:0], sdi};
                if (s_q.cnt != CNT_SAT) s_d.cnt = s_q.cnt + 1'b1;
            end else if (sck_fall && s_q.cnt != '0) begin
                s_d.tx = {s_q.tx[WORD_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sdo     = s_q.active ? s_q.tx[WORD_W-1] : 1'b0;
    assign sdo_oe  = s_q.active;
    assign commit  = s_q.commit;
    assign rx_word = s_q.word;

    // R2: first reply bit equals the TP status captured at the select edge
    a_r2_tp_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> sdo == $past(stat_word[TP_BIT]));
    // R3: commit only after exactly WORD_W clocks
    a_r3_commit_count: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(s_q.cnt) == CNT_FULL);
    // R5: reply held steady between serial falling edges
    a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active && !cs_fall && !sck_fall |=> $stable(s_q.tx));
    // R8: driver off once select has been high for a cycle
    a_r8_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_lvl) && cs_lvl |-> !sdo_oe);
endmodule

// File: rtl/spi_cmd_reg.sv
module spi_cmd_reg
    import spi_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [WORD_W-1:0] word,
    output cmd_t              cmd,
    output logic              srr_pulse
);
    typedef struct packed {
        cmd_t cmd;
        logic srr;
    } cr_t;

    cr_t c_d, c_q;

    always_comb begin
        c_d     = c_q;
        c_d.srr = 1'b0;
        if (commit) begin
            c_d.cmd = decode_cmd(word);
            c_d.srr = word[SRR_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cmd       = c_q.cmd;
    assign srr_pulse = c_q.srr;

    // R3: without a commit the command register does not move
    a_r3_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cmd));
    // R7: fault reset is a single-cycle pulse
    a_r7_srr_single: assert property (@(posedge clk) disable iff (!rst_n)
        srr_pulse |=> !srr_pulse);
    // R7: pulse only follows a commit
    a_r7_srr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        srr_pulse |-> $past(commit));
endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top
    import spi_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sclk,
    input  logic          spi_cs_n,
    input  logic          spi_sdi,
    output logic          spi_sdo,
    output logic          spi_sdo_oe,
    input  logic          temp_warn,
    input  logic [CH-1:0] hs_stat,
    input  logic [CH-1:0] ls_stat,
    input  logic          overload,
    output logic [CH-1:0] hs_on,
    output logic [CH-1:0] ls_on,
    output logic [CH-1:0] pwm_hs_sel,
    output logic [CH-1:0] pwm_ls_sel,
    output logic          oc_shutdown_en,
    output logic          run_en,
    output logic          fault_reset
);
    // bit 2: sdi, bit 1: cs_n, bit 0: sclk; cs_n idles high
    logic [2:0]        s_lvl, s_rise, s_fall;
    logic [WORD_W-1:0] stat_word;
    logic              commit;
    logic [WORD_W-1:0] rx_word;
    cmd_t              cmd;

    spi_sync #(.STAGES(SYNC_STAGES), .N(3), .INIT(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_sdi, spi_cs_n, spi_sclk}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    assign stat_word = build_status(temp_warn, hs_stat, ls_stat, overload);

    spi_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_lvl   (s_lvl[1]),
        .cs_fall  (s_fall[1]),
        .cs_rise  (s_rise[1]),
        .sck_rise (s_rise[0]),
        .sck_fall (s_fall[0]),
        .sdi      (s_lvl[2]),
        .stat_word(stat_word),
        .sdo      (spi_sdo),
        .sdo_oe   (spi_sdo_oe),
        .commit   (commit),
        .rx_word  (rx_word)
    );

    spi_cmd_reg u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .word     (rx_word),
        .cmd      (cmd),
        .srr_pulse(fault_reset)
    );

    assign hs_on          = cmd.hs;
    assign ls_on          = cmd.ls;
    assign pwm_hs_sel     = cmd.ph;
    assign pwm_ls_sel     = cmd.pl;
    assign oc_shutdown_en = cmd.ocs;
    assign run_en         = cmd.si;

    // R4: a commit always reflects the captured word's enables on the next cycle
    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> hs_on == $past(rx_word[HS_MSB -: CH]) && run_en == $past(rx_word[SI_BIT]));
endmodule

// File: tb/tb_spi_ctl_top.sv
`timescale 1ns/1ps
module tb_spi_ctl_top;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic sdo, sdo_oe;
    logic [7:0] stat_v = 8'h00; // {tp, hs[2:0], ls[2:0], ovl}
    logic [2:0] hs_on, ls_on, pwm_hs_sel, pwm_ls_sel;
    logic oc_shutdown_en, run_en, fault_reset;
    int checks = 0, errors = 0, srr_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_ctl_top dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(sdi),
        .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .temp_warn(stat_v[7]),
        .hs_stat(stat_v[6:4]), .ls_stat(stat_v[3:1]), .overload(stat_v[0]),
        .hs_on(hs_on), .ls_on(ls_on), .pwm_hs_sel(pwm_hs_sel), .pwm_ls_sel(pwm_ls_sel),
        .oc_shutdown_en(oc_shutdown_en), .run_en(run_en), .fault_reset(fault_reset)
    );

    always @(posedge clk) if (rst_n && fault_reset) srr_cnt <= srr_cnt + 1;

    function automatic logic [15:0] exp_reply(input logic [7:0] s);
        return {s[7], s[6:4], s[3:1], 8'b0, s[0]};
    endfunction
    function automatic logic [13:0] exp_cmd(input logic [15:0] w);
        return {w[15:4], w[3], w[1]};
    endfunction
    function automatic logic [13:0] outs();
        return {hs_on, ls_on, pwm_hs_sel, pwm_ls_sel, oc_shutdown_en, run_en};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // nbits rising edges; status may change to mid_stat after bit mid_at
    task automatic frame(input logic [15:0] w, input int nbits, input int mid_at,
                         input logic [7:0] mid_stat, output logic [15:0] rx);
        rx = '0;
        cs_n = 1'b0;
        wclk(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? w[15-i] : 1'b0;
            wclk(HALF);
            if (i < 16) rx[15-i] = sdo;
            sclk = 1'b1;
            wclk(HALF);
            sclk = 1'b0;
            if (i == mid_at) stat_v = mid_stat;
        end
        wclk(HALF);
        cs_n = 1'b1;
        wclk(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] rx, last, w;
        int c0;
        wclk(4);
        rst_n = 1'b1;
        wclk(4);
        // R1 reset state
        chk(outs() == 14'd0, "R1 outputs", 32'(outs()), 0);
        chk(fault_reset == 1'b0, "R1 fault_reset", 32'(fault_reset), 0);
        chk(sdo_oe == 1'b0, "R1/R8 sdo_oe", 32'(sdo_oe), 0);

        // R2 TP poll without clocks, both polarities
        for (int t = 0; t < 2; t++) begin
            stat_v = t ? 8'h80 : 8'h7F;
            cs_n = 1'b0;
            wclk(HALF);
            chk(sdo_oe == 1'b1, "R8 oe during frame", 32'(sdo_oe), 1);
            chk(sdo == stat_v[7], "R2 tp at select", 32'(sdo), 32'(stat_v[7]));
            cs_n = 1'b1;
            wclk(10);
            chk(sdo_oe == 1'b0, "R8 oe idle", 32'(sdo_oe), 0);
            chk(outs() == 14'd0, "R3 poll leaves cmd", 32'(outs()), 0);
        end
        chk(srr_cnt == 0, "R3 poll no pulse", srr_cnt, 0);

        // R9 frame accepted while inhibited (si bit 0)
        w = 16'hA5F8;
        frame(w, 16, -1, 8'h00, rx);
        chk(outs() == exp_cmd(w), "R9 inhibited frame", 32'(outs()), 32'(exp_cmd(w)));
        chk(run_en == 1'b0, "R9 run_en stays low", 32'(run_en), 0);

        // R4 R5 R6 R7 sweep over all status combinations
        for (int s = 0; s < 256; s++) begin
            w = 16'(s * 16'h9E37) ^ 16'h5A5A;
            stat_v = 8'(s);
            c0 = srr_cnt;
            frame(w, 16, -1, 8'h00, rx);
            chk(rx == exp_reply(8'(s)), "R5/R6 reply word", 32'(rx), 32'(exp_reply(8'(s))));
            chk(outs() == exp_cmd(w), "R4/R6 command load", 32'(outs()), 32'(exp_cmd(w)));
            chk(srr_cnt - c0 == int'(w[2]), "R7 pulse count", srr_cnt - c0, 32'(w[2]));
        end
        last = w;

        // R3 partial and overlong frames
        for (int n = 0; n <= 17; n++) begin
            if (n == 16) continue;
            c0 = srr_cnt;
            frame(~last | 16'h0004, n, -1, 8'h00, rx);
            chk(outs() == exp_cmd(last), "R3 bad count ignored", 32'(outs()), 32'(exp_cmd(last)));
            chk(srr_cnt == c0, "R3 no pulse", srr_cnt - c0, 0);
        end

        // R5 snapshot: status changes mid-frame
        stat_v = 8'hFF;
        frame(16'h0002, 16, 7, 8'h00, rx);
        chk(rx == exp_reply(8'hFF), "R5 snapshot", 32'(rx), 32'(exp_reply(8'hFF)));
        chk(run_en == 1'b1, "R4 run_en set", 32'(run_en), 1);
        stat_v = 8'h00;
        frame(16'h0004, 16, 3, 8'hFF, rx);
        chk(rx == 16'h0000, "R5 snapshot zero", 32'(rx), 0);
        chk(outs() == 14'd0, "R7 srr not stored", 32'(outs()), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule